// File: doc/BRIEF.md
# Interrupt Entry Frame Sequencer

This block runs the entry half of interrupt acceptance for a processor core that has two supervisor stacks, a master stack and an interrupt stack. When the core accepts an interrupt it pulses an accept strobe together with the accepted level and the vector number. The sequencer then captures the running status word, program counter and both stack pointers. It produces the updated status word and writes a four-halfword exception frame through a 16-bit memory write port with a ready handshake. Finally it requests the handler address from the vector table and signals completion.

An interrupt taken while the master bit is set is an outermost interrupt. It gets a normal frame on the master stack, followed by a second frame with a distinct format code on the interrupt stack, and afterwards the interrupt stack is the active one. An interrupt taken while the master bit is already clear is nested. It gets a single frame on the interrupt stack, and the master stack pointer is left unchanged. While a sequence is in progress, further accept strobes are ignored.

Top module: `irq_frame_seq`

## Requirements
- R1: While reset is held, the outputs wr_en_o, vec_req_o and done_o are 0, and sw_o, msp_o and isp_o are all zero.
- R2: An accept strobe seen while idle captures the inputs. From the next cycle, sw_o equals the captured status word with bit 12 (master) cleared, bit 13 (supervisor) set, bit 15 (trace enable) cleared and bits 10:8 (interrupt mask) set to the accepted level. All other bits are unchanged.
- R3: A frame is written as four halfword writes at ascending addresses base, base+2, base+4 and base+6. The data of these writes is, in that order: the captured status word, the program counter bits 31:16, the program counter bits 15:0, and the format/offset word. One write completes on each cycle where wr_en_o and wr_rdy_i are both high.
- R4: The format/offset word carries a format code in bits 15:12 and the vector number times four in bits 11:0. The code is 0 for a normal frame and 1 for the second frame of a stack switch.
- R5: If the captured status word has bit 12 set, the first frame is written at msp_i−8 with format 0 and the second at isp_i−8 with format 1. From the cycle after acceptance, msp_o = msp_i−8 and isp_o = isp_i−8.
- R6: If the captured status word has bit 12 clear, exactly one frame is written, at isp_i−8 with format 0. From the cycle after acceptance, isp_o = isp_i−8 and msp_o = msp_i.
- R7: While wr_rdy_i is low, a pending write keeps wr_en_o high and holds its address and data unchanged.
- R8: After the last write, vec_req_o rises with vec_addr_o equal to the vector number times four. It stays high until the cycle in which vec_ack_i is seen, and it is never high in the same cycle as wr_en_o. A vec_ack_i at any other time has no effect.
- R9: done_o is high for exactly one cycle, the cycle after vec_ack_i is accepted. The block is then idle and can accept again.
- R10: Accept strobes that arrive during a sequence (including its done cycle) are ignored. Changes to the status word, program counter or stack pointer inputs after acceptance do not alter the frame or the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Interrupt accept strobe |
| take_lvl_i | input | 3 | Accepted interrupt level |
| take_vec_i | input | 8 | Accepted vector number |
| sw_i | input | 16 | Current status word |
| pc_i | input | 32 | Current program counter |
| msp_i | input | 32 | Current master stack pointer |
| isp_i | input | 32 | Current interrupt stack pointer |
| wr_rdy_i | input | 1 | Memory write ready |
| vec_ack_i | input | 1 | Vector fetch acknowledge |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 32 | Memory write byte address |
| wr_data_o | output | 16 | Memory write halfword |
| sw_o | output | 16 | New status word |
| msp_o | output | 32 | New master stack pointer |
| isp_o | output | 32 | New interrupt stack pointer |
| vec_req_o | output | 1 | Vector fetch request |
| vec_addr_o | output | 32 | Vector fetch address |
| done_o | output | 1 | Sequence complete pulse |

## Verification
The bench exercises outermost and nested entries. An outermost entry that is mistaken for a nested one shows up as a missing second frame, a wrong format code, or an untouched master stack pointer. Irregular ready stalls and late vector acknowledges are used to catch a write pointer that advances without ready, or a request that drops early. The bench raises new accept strobes in the middle of a sequence and moves the program counter and stack inputs after acceptance, which exposes a design that recaptures its inputs. It also covers a level-7 entry with vector 255 and master stack pointer wraparound below zero, which exercises the full offset field and the address arithmetic.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;
  localparam int SW_W       = 16;
  localparam int SW_TRACE   = 15;
  localparam int SW_SUPER   = 13;
  localparam int SW_MASTER  = 12;
  localparam int SW_MASK_LO = 8;
  localparam int FMT_W      = 4;
  localparam logic [FMT_W-1:0] FMT_PLAIN  = 4'h0;
  localparam logic [FMT_W-1:0] FMT_SWITCH = 4'h1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_FETCH = 2'd2,
    ST_DONE  = 2'd3
  } seq_st_t;
endpackage

// File: rtl/irq_sw_xform.sv
module irq_sw_xform
  import irq_frame_pkg::*;
#(
  parameter int LW = 3
) (
  input  logic [SW_W-1:0] sw_i,
  input  logic [LW-1:0]   lvl_i,
  output logic [SW_W-1:0] sw_o
);
  always_comb begin
    sw_o                      = sw_i;
    sw_o[SW_MASTER]           = 1'b0;
    sw_o[SW_SUPER]            = 1'b1;
    sw_o[SW_TRACE]            = 1'b0;
    sw_o[SW_MASK_LO +: LW]    = lvl_i;
  end
endmodule

// File: rtl/irq_frame_word.sv
module irq_frame_word
  import irq_frame_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 8
) (
  input  logic [1:0]       sel_i,
  input  logic [SW_W-1:0]  sw_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [VW-1:0]    vec_i,
  input  logic [FMT_W-1:0] fmt_i,
  output logic [SW_W-1:0]  word_o
);
  localparam int OFFS_W = SW_W - FMT_W;

  logic [OFFS_W-1:0] offs;

  always_comb begin
    offs = OFFS_W'({vec_i, 2'b00});
    unique case (sel_i)
      2'd0:    word_o = sw_i;
      2'd1:    word_o = pc_i[AW-1 -: SW_W];
      2'd2:    word_o = pc_i[SW_W-1:0];
      default: word_o = {fmt_i, offs};
    endcase
  end
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irq_frame_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [LW-1:0] take_lvl_i,
  input  logic [VW-1:0] take_vec_i,
  input  logic [15:0]   sw_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] msp_i,
  input  logic [AW-1:0] isp_i,
  input  logic          wr_rdy_i,
  input  logic          vec_ack_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [15:0]   wr_data_o,
  output logic [15:0]   sw_o,
  output logic [AW-1:0] msp_o,
  output logic [AW-1:0] isp_o,
  output logic          vec_req_o,
  output logic [AW-1:0] vec_addr_o,
  output logic          done_o
);
  localparam logic [AW-1:0] FRAME_BYTES = AW'(8);
  localparam logic [1:0]    LAST_WORD   = 2'd3;

  seq_st_t         st_q, st_d;
  logic [1:0]      idx_q, idx_d;
  logic            sec_q, sec_d;
  logic            dual_q;
  logic [SW_W-1:0] sv_sw_q, sw_q, sw_new;
  logic [AW-1:0]   sv_pc_q, msp_q, isp_q, base;
  logic [VW-1:0]   sv_vec_q;
  logic            cap_en;
  logic [FMT_W-1:0] fmt;

  irq_sw_xform #(.LW(LW)) u_sw (
    .sw_i  (sw_i),
    .lvl_i (take_lvl_i),
    .sw_o  (sw_new)
  );

  irq_frame_word #(.AW(AW), .VW(VW)) u_word (
    .sel_i  (idx_q),
    .sw_i   (sv_sw_q),
    .pc_i   (sv_pc_q),
    .vec_i  (sv_vec_q),
    .fmt_i  (fmt),
    .word_o (wr_data_o)
  );

  assign cap_en = (st_q == ST_IDLE) && take_i;

  // next-state process
  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    sec_d = sec_q;
    unique case (st_q)
      ST_IDLE: begin
        if (take_i) begin
          st_d  = ST_WRITE;
          idx_d = 2'd0;
          sec_d = 1'b0;
        end
      end
      ST_WRITE: begin
        if (wr_rdy_i) begin
          if (idx_q == LAST_WORD) begin
            idx_d = 2'd0;
            if (dual_q && !sec_q) sec_d = 1'b1;
            else                  st_d  = ST_FETCH;
          end else begin
            idx_d = idx_q + 2'd1;
          end
        end
      end
      ST_FETCH: if (vec_ack_i) st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= 2'd0;
      sec_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      sec_q <= sec_d;
    end
  end

  // capture registers, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dual_q   <= 1'b0;
      sv_sw_q  <= '0;
      sv_pc_q  <= '0;
      sv_vec_q <= '0;
      sw_q     <= '0;
      msp_q    <= '0;
      isp_q    <= '0;
    end else if (cap_en) begin
      dual_q   <= sw_i[SW_MASTER];
      sv_sw_q  <= sw_i;
      sv_pc_q  <= pc_i;
      sv_vec_q <= take_vec_i;
      sw_q     <= sw_new;
      msp_q    <= sw_i[SW_MASTER] ? (msp_i - FRAME_BYTES) : msp_i;
      isp_q    <= isp_i - FRAME_BYTES;
    end
  end

  assign fmt        = (dual_q && sec_q) ? FMT_SWITCH : FMT_PLAIN;
  assign base       = (dual_q && !sec_q) ? msp_q : isp_q;
  assign wr_addr_o  = base + AW'({idx_q, 1'b0});
  assign wr_en_o    = (st_q == ST_WRITE);
  assign vec_req_o  = (st_q == ST_FETCH);
  assign vec_addr_o = AW'({sv_vec_q, 2'b00});
  assign done_o     = (st_q == ST_DONE);
  assign sw_o       = sw_q;
  assign msp_o      = msp_q;
  assign isp_o      = isp_q;

  // R2
  sw_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && take_i) |=> (!sw_o[SW_MASTER] && sw_o[SW_SUPER] && !sw_o[SW_TRACE]));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !wr_rdy_i) |=> (wr_en_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req_o && !vec_ack_i) |=> vec_req_o);

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_req_o && wr_en_o));

  // R9
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req_o && vec_ack_i) |=> (done_o && !vec_req_o));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> ($stable(sw_o) && $stable(isp_o) && $stable(msp_o)));
endmodule

// File: tb/sim_irq_frame_seq.sv
module sim_irq_frame_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        take_i;
  logic [2:0]  take_lvl_i;
  logic [7:0]  take_vec_i;
  logic [15:0] sw_i;
  logic [31:0] pc_i, msp_i, isp_i;
  logic        wr_rdy_i, vec_ack_i;
  logic        wr_en_o, vec_req_o, done_o;
  logic [31:0] wr_addr_o, msp_o, isp_o, vec_addr_o;
  logic [15:0] wr_data_o, sw_o;

  irq_frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .take_lvl_i(take_lvl_i),
    .take_vec_i(take_vec_i), .sw_i(sw_i), .pc_i(pc_i), .msp_i(msp_i),
    .isp_i(isp_i), .wr_rdy_i(wr_rdy_i), .vec_ack_i(vec_ack_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .sw_o(sw_o), .msp_o(msp_o), .isp_o(isp_o), .vec_req_o(vec_req_o),
    .vec_addr_o(vec_addr_o), .done_o(done_o)
  );

  always #2.5 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string ctx   = "base";
  bit    stall = 1'b0;
  bit    spur  = 1'b0;
  int    ack_lat = 0;
  int    ack_cnt = 0;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, ctx, act, exp);
    end
  endtask

  // behavioural reference model
  logic [47:0] m_q[$];
  bit          m_busy, m_fetch, m_done;
  logic [15:0] m_sw;
  logic [31:0] m_msp, m_isp, m_vaddr;

  function automatic logic [15:0] fvo(input logic [3:0] f, input logic [7:0] v);
    return {f, 12'(v) * 12'd4};
  endfunction

  task automatic push_frame(input logic [31:0] b, input logic [15:0] s, input logic [31:0] p,
                            input logic [3:0] f, input logic [7:0] v);
    m_q.push_back({b,      s});
    m_q.push_back({b + 2,  p[31:16]});
    m_q.push_back({b + 4,  p[15:0]});
    m_q.push_back({b + 6,  fvo(f, v)});
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete();
      m_busy = 0; m_fetch = 0; m_done = 0;
      m_sw = 0; m_msp = 0; m_isp = 0; m_vaddr = 0;
    end else if (m_done) begin
      m_done = 0;
      m_busy = 0;
    end else if (m_fetch) begin
      if (vec_ack_i) begin m_fetch = 0; m_done = 1; end
    end else if (m_q.size() > 0) begin
      if (wr_rdy_i) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) m_fetch = 1;
      end
    end else if (!m_busy && take_i) begin
      m_busy  = 1;
      m_vaddr = 32'(take_vec_i) * 4;
      m_sw    = sw_i;
      m_sw[12] = 1'b0;
      m_sw[13] = 1'b1;
      m_sw[15] = 1'b0;
      m_sw[10:8] = take_lvl_i;
      m_isp   = isp_i - 8;
      if (sw_i[12]) begin
        m_msp = msp_i - 8;
        push_frame(m_msp, sw_i, pc_i, 4'h0, take_vec_i);
        push_frame(m_isp, sw_i, pc_i, 4'h1, take_vec_i);
      end else begin
        m_msp = msp_i;
        push_frame(m_isp, sw_i, pc_i, 4'h0, take_vec_i);
      end
    end
  end

  // environment responders
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_rdy_i = stall ? lfsr[0] : 1'b1;
    if (vec_req_o) begin
      ack_cnt++;
      vec_ack_i = (ack_cnt > ack_lat);
    end else begin
      ack_cnt = 0;
      vec_ack_i = spur;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(wr_en_o == (m_q.size() > 0), "R3 write strobe", 64'(wr_en_o), 64'(m_q.size() > 0));
      if (m_q.size() > 0) begin
        chk(wr_addr_o == m_q[0][47:16], "R5/R6 write address", 64'(wr_addr_o), 64'(m_q[0][47:16]));
        chk(wr_data_o == m_q[0][15:0], "R3/R4 write data", 64'(wr_data_o), 64'(m_q[0][15:0]));
      end
      chk(vec_req_o == m_fetch, "R8 vector request", 64'(vec_req_o), 64'(m_fetch));
      if (m_fetch) chk(vec_addr_o == m_vaddr, "R8 vector address", 64'(vec_addr_o), 64'(m_vaddr));
      chk(done_o == m_done, "R9 done pulse", 64'(done_o), 64'(m_done));
      chk(sw_o == m_sw, "R2 status word", 64'(sw_o), 64'(m_sw));
      chk(msp_o == m_msp, "R5/R6 master sp", 64'(msp_o), 64'(m_msp));
      chk(isp_o == m_isp, "R5/R6 interrupt sp", 64'(isp_o), 64'(m_isp));
    end
  end

  task automatic fire(input logic [2:0] l, input logic [7:0] v, input logic [15:0] s,
                      input logic [31:0] p, input logic [31:0] m, input logic [31:0] i);
    @(negedge clk);
    take_i = 1'b1; take_lvl_i = l; take_vec_i = v; sw_i = s; pc_i = p; msp_i = m; isp_i = i;
    @(negedge clk);
    take_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; take_i = 0; take_lvl_i = 0; take_vec_i = 0; sw_i = 0;
    pc_i = 0; msp_i = 0; isp_i = 0; wr_rdy_i = 1; vec_ack_i = 0;
    repeat (3) @(negedge clk);
    ctx = "R1 reset";
    chk(!wr_en_o && !vec_req_o && !done_o, "R1 strobes low", {wr_en_o, vec_req_o, done_o}, 0);
    chk(sw_o == 0, "R1 status word", 64'(sw_o), 0);
    chk(msp_o == 0 && isp_o == 0, "R1 stack pointers", {msp_o, isp_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    ctx = "outermost";
    fire(3'd4, 8'h40, 16'hB005, 32'h1234_5678, 32'h0000_2000, 32'h0000_3000);
    wait_idle();

    ctx = "nested";
    fire(3'd6, 8'h19, 16'h2300, 32'hCAFE_0102, 32'h0000_1000, 32'h0000_2FF8);
    wait_idle();

    ctx = "R7 stall with late ack, level 7 vector 255, sp wrap";
    stall = 1; ack_lat = 3;
    fire(3'd7, 8'hFF, 16'h9000, 32'hFFFF_FFFE, 32'h0000_0004, 32'h0000_0010);
    wait_idle();

    ctx = "R10 ignore mid-sequence strobes";
    fire(3'd0, 8'h00, 16'h1700, 32'h0000_8000, 32'h0000_4000, 32'h0000_5000);
    take_i = 1'b1; take_lvl_i = 3'd5; take_vec_i = 8'h09; sw_i = 16'h0000;
    pc_i = 32'hDEAD_BEEF; msp_i = 32'h7777_0000; isp_i = 32'h6666_0000;
    repeat (6) @(negedge clk);
    take_i = 1'b0;
    wait_idle();

    ctx = "R8 spurious ack outside fetch";
    stall = 0; ack_lat = 1; spur = 1;
    repeat (3) @(negedge clk);
    fire(3'd2, 8'h81, 16'h0200, 32'h0101_0202, 32'h0000_0100, 32'h0000_0200);
    spur = 0;
    wait_idle();

    ctx = "R9 back-to-back";
    fire(3'd1, 8'h02, 16'h3000, 32'hAAAA_5555, 32'h0001_0000, 32'h0002_0000);
    while (!done_o) @(negedge clk);
    take_i = 1'b1; take_lvl_i = 3'd3; take_vec_i = 8'h33; sw_i = 16'h1000;
    pc_i = 32'h0BAD_F00D; msp_i = 32'h0000_0800; isp_i = 32'h0000_0C00;
    @(negedge clk);
    @(negedge clk);
    take_i = 1'b0;
    wait_idle();

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired [%s] actual=%0d expected=<100000", ctx, cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule